// File: doc/BRIEF.md
# Slow-Clock Timebase With Sleep and Wake Timestamps

This block keeps a free-running 48-bit count of slow-clock cycles and makes it visible to software on a fast bus clock. The two clocks are unrelated. Software does not read the live counter. It asks for a copy, waits until the copy is ready, and then reads that copy as a low word and a high word. The request goes to the slow domain and the completion comes back through toggle synchronizers, so no multi-bit value crosses a domain while it is changing.

A power controller, which is outside this block, sends two single-cycle pulses in the slow domain: one when the system goes to sleep and one when it wakes. Each pulse stores the counter value into its own timestamp pair. Software gets the time spent asleep by subtracting the sleep stamp from the wake stamp. A second control bit lets software line up with the slow clock. Software writes it to 1 and polls it. Hardware clears it after a slow clock edge has been seen.

Top module: `rtc_sleep_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter is zero and every readable word reads 0: control at address 0, snapshot low/high at 1/2, sleep low/high at 3/4, wake low/high at 5/6. Address 7 always reads 0.
- R2: The counter increases by exactly one on every slow clock edge after reset is released.
- R3: Writing address 0 with bit 0 set starts a snapshot request. Bit 0 of address 0 reads 1 from the cycle after the write until the snapshot is valid, and then clears without any further write.
- R4: A completed snapshot holds a counter value that is no smaller than the count at the request and no larger than the count when completion is seen. Address 1 returns bits 31:0 and address 2 returns bits 47:32 in its bits 15:0, with bits 31:16 reading 0.
- R5: While a snapshot request is pending, addresses 1 and 2 keep returning the previous snapshot.
- R6: A sleep pulse stores the counter value of the slow edge that samples it into addresses 3/4. The wake pair does not change.
- R7: A wake pulse stores the counter value of the slow edge that samples it into addresses 5/6. The sleep pair does not change.
- R8: The wake stamp minus the sleep stamp equals the number of slow cycles between the two pulses.
- R9: Writing address 0 with bit 1 set makes bit 1 read 1. Hardware clears it only after at least one slow clock edge has occurred, and it then reads 0.
- R10: Control writes with both bits 0 start nothing. Writes to addresses 1 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| bus_addr | input | 3 | Word address of the access |
| bus_we | input | 1 | Write strobe, sampled on clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sleep_evt | input | 1 | One slow-cycle pulse at sleep entry |
| wake_evt | input | 1 | One slow-cycle pulse at wakeup |

## Verification
The bench reads the snapshot words straight after a request. A design that copied the new value on the bus side too early would show a changed word while the request bit still reads 1. The completed snapshot must fall inside a window the bench brackets with its own count of slow edges, so a capture of a stale or wrongly shifted counter falls outside that window. Sleep and wake stamps are checked for exact values and for not disturbing each other, which catches swapped or shared capture enables. The edge-wait bit is checked to clear only after the bench has counted a slow edge, which catches a bit that clears immediately or never clears.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// rtc_pkg: shared constants for the slow-clock timebase.
// Assumes the counter is wider than one bus word and narrower than two.
package rtc_pkg;
    localparam int ADDR_W = 3;

    // Word addresses of the register view.
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SNAP_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SNAP_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SLEEP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_SLEEP_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_WAKE_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_WAKE_HI  = 3'd6;

    // Control bit positions; software relies on them.
    localparam int CTRL_SNAP_BIT = 0;
    localparam int CTRL_EDGE_BIT = 1;

    // Handshake channels crossing between the domains.
    localparam int CH_SNAP = 0;
    localparam int CH_EDGE = 1;
    localparam int N_CH    = 2;

    // Timestamp slots captured from power events.
    localparam int TS_SLEEP = 0;
    localparam int TS_WAKE  = 1;
    localparam int N_TS     = 2;
endpackage

// File: rtl/rtc_bit_sync.sv
`timescale 1ns/1ps
// rtc_bit_sync: multi-flop synchronizer for one level/toggle signal.
// Assumes the input changes no faster than the destination clock can sample it.
module rtc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
`timescale 1ns/1ps
// rtc_slow_core: slow-domain counter, event timestamps and request responders.
// Assumes request toggles arrive already synchronized to slow_clk and that
// sleep/wake pulses last exactly one slow cycle.
module rtc_slow_core
    import rtc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             sleep_evt,
    input  logic             wake_evt,
    input  logic [N_CH-1:0]  req_s,
    output logic [N_CH-1:0]  ack_tgl,
    output logic [CNT_W-1:0] snap_val,
    output logic [CNT_W-1:0] stamp [N_TS]
);
    logic [CNT_W-1:0] cnt_q;
    logic [N_TS-1:0]  evt;
    logic             snap_hit;

    assign evt[TS_SLEEP] = sleep_evt;
    assign evt[TS_WAKE]  = wake_evt;
    assign snap_hit      = req_s[CH_SNAP] ^ ack_tgl[CH_SNAP];

    // Free-running count of slow cycles.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Acknowledge each channel by following its synchronized request toggle.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) ack_tgl <= '0;
        else        ack_tgl <= req_s;
    end

    // Capture the counter on the edge that sees a new snapshot request.
    always_ff @(posedge slow_clk) begin
        if (!rst_n)        snap_val <= '0;
        else if (snap_hit) snap_val <= cnt_q;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_TS; gi++) begin : g_stamp
            // Each event pulse overwrites only its own timestamp.
            always_ff @(posedge slow_clk) begin
                if (!rst_n)       stamp[gi] <= '0;
                else if (evt[gi]) stamp[gi] <= cnt_q;
            end

            assert_stamp_cap_R6: assert property (@(posedge slow_clk) disable iff (!rst_n)
                evt[gi] |=> stamp[gi] == $past(cnt_q));
            assert_stamp_hold_R7: assert property (@(posedge slow_clk) disable iff (!rst_n)
                !evt[gi] |=> $stable(stamp[gi]));
        end
    endgenerate

    assert_cnt_step_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rtc_bus_regs.sv
`timescale 1ns/1ps
// rtc_bus_regs: bus-domain register view, request issuers and snapshot copy.
// Assumes the slow-domain snapshot is stable whenever an acknowledgement
// toggle arrives, since no new request is issued while one is pending.
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ack_b,
    output logic [N_CH-1:0]   req_tgl,
    input  logic [CNT_W-1:0]  snap_val,
    input  logic [CNT_W-1:0]  stamp [N_TS]
);
    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    logic [N_CH-1:0]  pend_q;
    logic [N_CH-1:0]  ack_seen;
    logic [N_CH-1:0]  done;
    logic [N_CH-1:0]  wr_bit;
    logic [CNT_W-1:0] snap_q;
    logic             ctrl_wr;

    assign ctrl_wr             = bus_we && (bus_addr == A_CTRL);
    assign wr_bit[CH_SNAP]     = bus_wdata[CTRL_SNAP_BIT];
    assign wr_bit[CH_EDGE]     = bus_wdata[CTRL_EDGE_BIT];
    assign done                = ack_b ^ ack_seen;

    // Remember the last acknowledgement level to spot new toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_seen <= '0;
        else        ack_seen <= ack_b;
    end

    genvar gc;
    generate
        for (gc = 0; gc < N_CH; gc++) begin : g_chan
            // Issue a request toggle on a write and hold pending until acknowledged.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[gc]  <= 1'b0;
                    req_tgl[gc] <= 1'b0;
                end else if (done[gc]) begin
                    pend_q[gc]  <= 1'b0;
                end else if (ctrl_wr && wr_bit[gc] && !pend_q[gc]) begin
                    pend_q[gc]  <= 1'b1;
                    req_tgl[gc] <= ~req_tgl[gc];
                end
            end

            assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                pend_q[gc] && !done[gc] |=> pend_q[gc]);
            assert_no_spur_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
                done[gc] |-> pend_q[gc]);
        end
    endgenerate

    // Copy the slow-domain snapshot only when its completion arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)             snap_q <= '0;
        else if (done[CH_SNAP]) snap_q <= snap_val;
    end

    // Split a counter value into its high bus word, zero padded.
    function automatic logic [DATA_W-1:0] hi_word(input logic [CNT_W-1:0] v);
        return {{PAD_W{1'b0}}, v[CNT_W-1:DATA_W]};
    endfunction

    // Drive read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_SNAP_BIT] = pend_q[CH_SNAP];
                bus_rdata[CTRL_EDGE_BIT] = pend_q[CH_EDGE];
            end
            A_SNAP_LO:  bus_rdata = snap_q[DATA_W-1:0];
            A_SNAP_HI:  bus_rdata = hi_word(snap_q);
            A_SLEEP_LO: bus_rdata = stamp[TS_SLEEP][DATA_W-1:0];
            A_SLEEP_HI: bus_rdata = hi_word(stamp[TS_SLEEP]);
            A_WAKE_LO:  bus_rdata = stamp[TS_WAKE][DATA_W-1:0];
            A_WAKE_HI:  bus_rdata = hi_word(stamp[TS_WAKE]);
            default:    bus_rdata = '0;
        endcase
    end

    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done[CH_SNAP] |=> $stable(snap_q));
endmodule

// File: rtl/rtc_sleep_timer.sv
`timescale 1ns/1ps
// rtc_sleep_timer: slow-clock timebase with snapshot reads and sleep/wake stamps.
// Assumes rst_n is held low across several edges of both clocks, and that
// timestamp words are read only while no power event is in flight.
module rtc_sleep_timer
    import rtc_pkg::*;
#(
    parameter int CNT_W       = 48,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_evt,
    input  logic              wake_evt
);
    logic [N_CH-1:0]  req_tgl;
    logic [N_CH-1:0]  req_s;
    logic [N_CH-1:0]  ack_tgl;
    logic [N_CH-1:0]  ack_b;
    logic [CNT_W-1:0] snap_val;
    logic [CNT_W-1:0] stamp [N_TS];

    genvar gs;
    generate
        for (gs = 0; gs < N_CH; gs++) begin : g_cross
            rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_to_slow (
                .clk(slow_clk), .rst_n(rst_n), .d(req_tgl[gs]), .q(req_s[gs]));
            rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_to_bus (
                .clk(clk), .rst_n(rst_n), .d(ack_tgl[gs]), .q(ack_b[gs]));
        end
    endgenerate

    rtc_slow_core #(.CNT_W(CNT_W)) u_core (
        .slow_clk (slow_clk),
        .rst_n    (rst_n),
        .sleep_evt(sleep_evt),
        .wake_evt (wake_evt),
        .req_s    (req_s),
        .ack_tgl  (ack_tgl),
        .snap_val (snap_val),
        .stamp    (stamp)
    );

    rtc_bus_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ack_b    (ack_b),
        .req_tgl  (req_tgl),
        .snap_val (snap_val),
        .stamp    (stamp)
    );
endmodule

// File: tb/rtc_sleep_timer_bench.sv
`timescale 1ns/1ps
module rtc_sleep_timer_bench;
    logic        clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sleep_evt = 1'b0;
    logic        wake_evt = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    longint unsigned model_cnt = 0;

    always #2.5 clk = ~clk;
    always #50  slow_clk = ~slow_clk;

    // Independent count of slow edges since reset release.
    always @(posedge slow_clk) begin
        if (!rst_n) model_cnt <= 0;
        else        model_cnt <= model_cnt + 1;
    end

    rtc_sleep_timer u_rtc_sleep_timer (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sleep_evt(sleep_evt), .wake_evt(wake_evt)
    );

    task automatic chk_eq(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input longint unsigned act,
                           input longint unsigned lo, input longint unsigned hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read64(input logic [2:0] a_lo, output longint unsigned v);
        logic [31:0] lo, hi;
        bus_read(a_lo, lo);
        bus_read(a_lo + 3'd1, hi);
        v = {hi, lo};
    endtask

    // Poll a control bit until it reads 0; returns 1 on success.
    task automatic wait_ctrl_clear(input int bitpos, output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            bus_read(3'd0, d);
            if (!d[bitpos]) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            bus_read(a[2:0], d);
            chk_eq($sformatf("R1 reset addr %0d", a), d, 0);
        end
    endtask

    task automatic t_snapshot(input int round);
        longint unsigned prev, v, lo, hi;
        logic [31:0] d;
        bit ok;
        read64(3'd1, prev);
        lo = model_cnt;
        bus_write(3'd0, 32'h1);
        bus_read(3'd0, d);
        chk_eq($sformatf("R3 pending bit set round %0d", round), d[0], 1);
        read64(3'd1, v);
        chk_eq($sformatf("R5 previous snapshot while pending round %0d", round), v, prev);
        wait_ctrl_clear(0, ok);
        chk_eq($sformatf("R3 pending self-clears round %0d", round), ok, 1);
        hi = model_cnt;
        read64(3'd1, v);
        chk_rng($sformatf("R2 R4 snapshot window round %0d", round), v, lo, hi);
        chk_eq($sformatf("R4 high word upper bits zero round %0d", round), v >> 48, 0);
    endtask

    task automatic t_edge_wait;
        logic [31:0] d;
        longint unsigned start;
        bit ok;
        @(posedge slow_clk);
        #7;
        start = model_cnt;
        bus_write(3'd0, 32'h2);
        bus_read(3'd0, d);
        chk_eq("R9 edge bit reads 1", d[1], 1);
        chk_eq("R9 edge write leaves snapshot idle", d[0], 0);
        wait_ctrl_clear(1, ok);
        chk_eq("R9 edge bit cleared by hardware", ok, 1);
        chk_eq("R9 slow edge seen before clear", model_cnt > start, 1);
    endtask

    task automatic t_sleep_wake(input int gap);
        longint unsigned exp_s, exp_w, v_s, v_w, wake_before, sleep_after;
        read64(3'd5, wake_before);
        @(posedge slow_clk);
        #10;
        exp_s = model_cnt;
        sleep_evt = 1'b1;
        @(posedge slow_clk);
        #10;
        sleep_evt = 1'b0;
        read64(3'd3, v_s);
        chk_eq($sformatf("R6 sleep stamp gap %0d", gap), v_s, exp_s);
        read64(3'd5, v_w);
        chk_eq($sformatf("R6 wake pair untouched gap %0d", gap), v_w, wake_before);
        repeat (gap - 1) @(posedge slow_clk);
        #10;
        exp_w = model_cnt;
        wake_evt = 1'b1;
        @(posedge slow_clk);
        #10;
        wake_evt = 1'b0;
        read64(3'd5, v_w);
        chk_eq($sformatf("R7 wake stamp gap %0d", gap), v_w, exp_w);
        read64(3'd3, sleep_after);
        chk_eq($sformatf("R7 sleep pair untouched gap %0d", gap), sleep_after, exp_s);
        chk_eq($sformatf("R8 duration gap %0d", gap), v_w - sleep_after, gap);
    endtask

    task automatic t_ignored;
        longint unsigned snap0, sleep0, v;
        logic [31:0] d;
        read64(3'd1, snap0);
        read64(3'd3, sleep0);
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd3, 32'hA5A5_A5A5);
        bus_write(3'd7, 32'h3);
        bus_read(3'd0, d);
        chk_eq("R10 zero control write starts nothing", d, 0);
        repeat (8) @(posedge slow_clk);
        bus_read(3'd0, d);
        chk_eq("R10 control still idle", d, 0);
        read64(3'd1, v);
        chk_eq("R10 snapshot unchanged", v, snap0);
        read64(3'd3, v);
        chk_eq("R10 sleep stamp unchanged", v, sleep0);
        bus_read(3'd7, d);
        chk_eq("R1 address 7 reads 0", d, 0);
    endtask

    initial begin
        repeat (4) @(posedge slow_clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        repeat (3) @(posedge slow_clk);
        t_snapshot(0);
        repeat (5) @(posedge slow_clk);
        t_snapshot(1);
        t_edge_wait();
        t_sleep_wake(13);
        t_sleep_wake(1);
        t_ignored();
        t_snapshot(2);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule